// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Arbiter

This block decides which interrupt an 8-bit processor core takes next and where the core finds its handler. It has seventeen priority levels. Level 0 is a power-on entry that cannot be masked. Levels 1 to 15 are maskable sources, and each of them has a request bit and an enable bit. Level 16 is the software break, which also cannot be masked. The request bits are set by internal event pulses from timers and serial units. They are also set by edges on external pins, by a key-matrix wake-up and by a shared level that serves either an external trigger pin or analog conversion completion.

The core reads the pending line, the winning level number and the two byte addresses of that level's vector. When it takes the interrupt it raises an accept strobe. In that cycle the block clears the accepted request and emits a strobe telling the core to set its interrupt-disable flag. Saving the program counter and status is left to the core.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the block reports a pending interrupt at level 0 with vector bytes FFFD/FFFC. It keeps reporting it until the core accepts it, and the accept clears it.
- R2: A maskable level k (1..15) is eligible only when its request bit, its enable bit and `i_flag`=0 all hold. Bus bit k-1 of `wr_data` and of the registers belongs to level k.
- R3: Among eligible requests the lowest level number wins. Level 0 beats every other level, and the break level 16 loses to every eligible maskable level.
- R4: A bus write with `wr_req`=1 clears each request bit written 0 and leaves each bit written 1 unchanged. A write with `wr_en`=1 loads the enable register.
- R5: When `ack`=1 while `irq_pend`=1, the accepted request is cleared on that clock edge and `set_iflag` is 1 in that cycle. Any other pending requests stay latched.
- R6: A one-cycle `brk_req` latches a break request at level 16. That request is taken even with `i_flag`=1 and with every enable bit 0.
- R7: `vec_hi` equals FFFD minus twice the level, and `vec_lo` equals `vec_hi` minus 1.
- R8: `pin_ext` bits 0..4 feed levels 1, 2, 9, 10 and 12. `edge_rise` bit 1 selects the rising edge and bit 0 selects the falling edge. After two synchronizer flops, the request is visible on the third clock after the pin changes.
- R9: When the AND of all `key_in` lines falls, level 14 is requested on the third clock.
- R10: With `lvl15_pin_sel`=1, level 15 is requested on a falling edge of `adt_pin`, three clocks later. With `lvl15_sel`=0 it is requested one clock after `ad_eoc` rises. A change of `edge_rise` or of `lvl15_pin_sel` that turns the selected level from inactive to active sets the request one clock later.
- R11: `int_evt` bits 0..7 set levels 3, 4, 5, 6, 7, 8, 11 and 13 on the next clock. A hardware set wins over a clear by accept in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_flag | input | 1 | Core interrupt-disable flag |
| brk_req | input | 1 | Break instruction strobe |
| int_evt | input | 8 | Internal event pulses |
| pin_ext | input | 5 | External edge-triggered pins |
| edge_rise | input | 5 | Per-pin edge select, 1 = rising |
| key_in | input | KEY_W | Key wake-up lines |
| adt_pin | input | 1 | External trigger pin for level 15 |
| ad_eoc | input | 1 | Conversion-complete level for level 15 |
| lvl15_pin_sel | input | 1 | Level 15 source, 1 = trigger pin |
| wr_req | input | 1 | Write strobe to request register |
| wr_en | input | 1 | Write strobe to enable register |
| wr_data | input | 15 | Bus write data |
| ack | input | 1 | Core accepts the reported interrupt |
| irq_pend | output | 1 | An interrupt is ready to be taken |
| src_idx | output | 5 | Winning level number |
| vec_hi | output | 16 | Address of vector high byte |
| vec_lo | output | 16 | Address of vector low byte |
| set_iflag | output | 1 | Core must set its disable flag |

## Verification
The arbiter's outputs are combinational from the request, enable and latch state. A corrupted request or enable bit therefore shows on `src_idx` and the vector in the same cycle in which the bad state exists. A request that fails to clear on accept shows up as the same level being reported again on the very next cycle. A synchronizer or edge-history fault moves the cycle in which a pin request appears, or creates a request where none should appear. The bench samples exact cycles to catch this.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NUM_MASK = 15;
    localparam int NUM_EXT  = 5;
    localparam int NUM_INT  = 8;
    localparam int NUM_LVL  = NUM_MASK + 2;
    localparam int IDX_W    = $clog2(NUM_LVL);
    localparam int BIT_W    = $clog2(NUM_MASK);
    localparam int IDX_BRK  = NUM_MASK + 1;
    localparam int LVL_KEY  = 14;
    localparam int LVL_SH   = 15;
    localparam logic [15:0] VEC_TOP = 16'hFFFD;

    // level fed by each external edge pin
    function automatic int ext_level(int i);
        case (i)
            0:       return 1;
            1:       return 2;
            2:       return 9;
            3:       return 10;
            default: return 12;
        endcase
    endfunction

    // level fed by each internal event pulse
    function automatic int evt_level(int i);
        case (i)
            0:       return 3;
            1:       return 4;
            2:       return 5;
            3:       return 6;
            4:       return 7;
            5:       return 8;
            6:       return 11;
            default: return 13;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] pulse
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    // history starts active so a level already active at reset does not fire
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign pulse = lvl & ~prev_q;
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank
    import irq_vec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_MASK-1:0] set_vec,
    input  logic [NUM_MASK-1:0] clr_vec,
    input  logic                wr_req,
    input  logic                wr_en,
    input  logic [NUM_MASK-1:0] wr_data,
    output logic [NUM_MASK-1:0] req_q,
    output logic [NUM_MASK-1:0] en_q
);
    typedef struct packed {
        logic [NUM_MASK-1:0] req;
        logic [NUM_MASK-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        logic [NUM_MASK-1:0] keep;
        st_d = st_q;
        keep = wr_req ? wr_data : '1;
        st_d.req = (st_q.req & ~clr_vec & keep) | set_vec;
        if (wr_en) st_d.en = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_q = st_q.req;
    assign en_q  = st_q.en;

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & ~$past(req_q) & ~$past(set_vec)) == '0)); // R4

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wr_data))); // R4
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_vec_pkg::*;
(
    input  logic [NUM_MASK-1:0] req,
    input  logic [NUM_MASK-1:0] en,
    input  logic                i_flag,
    input  logic                rst_pend,
    input  logic                brk_pend,
    output logic                pend,
    output logic [IDX_W-1:0]    idx,
    output logic [15:0]         vec_hi,
    output logic [15:0]         vec_lo
);
    always_comb begin
        pend = 1'b0;
        idx  = '0;
        if (brk_pend) begin
            pend = 1'b1;
            idx  = IDX_W'(IDX_BRK);
        end
        for (int i = NUM_MASK - 1; i >= 0; i--) begin
            if (req[i] && en[i] && !i_flag) begin
                pend = 1'b1;
                idx  = IDX_W'(i + 1);
            end
        end
        if (rst_pend) begin
            pend = 1'b1;
            idx  = '0;
        end
    end

    always_comb begin
        vec_hi = VEC_TOP - 16'({idx, 1'b0});
        vec_lo = {vec_hi[15:1], 1'b0};
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int KEY_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i_flag,
    input  logic                brk_req,
    input  logic [NUM_INT-1:0]  int_evt,
    input  logic [NUM_EXT-1:0]  pin_ext,
    input  logic [NUM_EXT-1:0]  edge_rise,
    input  logic [KEY_W-1:0]    key_in,
    input  logic                adt_pin,
    input  logic                ad_eoc,
    input  logic                lvl15_pin_sel,
    input  logic                wr_req,
    input  logic                wr_en,
    input  logic [NUM_MASK-1:0] wr_data,
    input  logic                ack,
    output logic                irq_pend,
    output logic [IDX_W-1:0]    src_idx,
    output logic [15:0]         vec_hi,
    output logic [15:0]         vec_lo,
    output logic                set_iflag
);
    localparam int SYNC_W = NUM_EXT + KEY_W + 1;
    localparam int DET_W  = NUM_EXT + 2;

    typedef struct packed {
        logic rst_pend;
        logic brk_pend;
    } top_t;

    top_t st_d, st_q;

    logic [SYNC_W-1:0]   pin_s;
    logic [DET_W-1:0]    det_lvl;
    logic [DET_W-1:0]    det_pulse;
    logic [NUM_MASK-1:0] set_vec;
    logic [NUM_MASK-1:0] clr_vec;
    logic [NUM_MASK-1:0] req_q;
    logic [NUM_MASK-1:0] en_q;
    logic                accept;
    logic                is_mask;
    logic [BIT_W-1:0]    mask_bit;

    irq_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({adt_pin, key_in, pin_ext}),
        .dout  (pin_s)
    );

    // polarity-adjusted levels; a select change flips them directly
    always_comb begin
        for (int i = 0; i < NUM_EXT; i++) begin
            det_lvl[i] = pin_s[i] ^ ~edge_rise[i];
        end
        det_lvl[NUM_EXT]     = ~&pin_s[NUM_EXT +: KEY_W];
        det_lvl[NUM_EXT + 1] = lvl15_pin_sel ? ~pin_s[SYNC_W-1] : ad_eoc;
    end

    irq_rise_det #(.W(DET_W)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (det_lvl),
        .pulse (det_pulse)
    );

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_EXT; i++) begin
            set_vec[ext_level(i) - 1] = set_vec[ext_level(i) - 1] | det_pulse[i];
        end
        for (int i = 0; i < NUM_INT; i++) begin
            set_vec[evt_level(i) - 1] = set_vec[evt_level(i) - 1] | int_evt[i];
        end
        set_vec[LVL_KEY - 1] = set_vec[LVL_KEY - 1] | det_pulse[NUM_EXT];
        set_vec[LVL_SH - 1]  = set_vec[LVL_SH - 1]  | det_pulse[NUM_EXT + 1];
    end

    assign accept   = ack && irq_pend;
    assign is_mask  = (src_idx != '0) && (src_idx != IDX_W'(IDX_BRK));
    assign mask_bit = BIT_W'(src_idx - IDX_W'(1));

    always_comb begin
        clr_vec = '0;
        if (accept && is_mask) clr_vec[mask_bit] = 1'b1;
    end

    irq_req_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .wr_req  (wr_req),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .req_q   (req_q),
        .en_q    (en_q)
    );

    always_comb begin
        st_d = st_q;
        if (accept && src_idx == '0) st_d.rst_pend = 1'b0;
        st_d.brk_pend = (st_q.brk_pend && !(accept && src_idx == IDX_W'(IDX_BRK)))
                        || brk_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rst_pend: 1'b1, brk_pend: 1'b0};
        else        st_q <= st_d;
    end

    irq_arbiter u_arb (
        .req      (req_q),
        .en       (en_q),
        .i_flag   (i_flag),
        .rst_pend (st_q.rst_pend),
        .brk_pend (st_q.brk_pend),
        .pend     (irq_pend),
        .idx      (src_idx),
        .vec_hi   (vec_hi),
        .vec_lo   (vec_lo)
    );

    assign set_iflag = accept;

    AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_pend |-> (irq_pend && src_idx == '0)); // R1

    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && is_mask) |-> (!i_flag && req_q[mask_bit] && en_q[mask_bit])); // R2

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_mask && !set_vec[mask_bit]) |=> !req_q[$past(mask_bit)]); // R5

    AST_BRK_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.brk_pend && !st_q.rst_pend && i_flag) |-> (irq_pend && src_idx == IDX_W'(IDX_BRK))); // R6

    AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> (vec_hi == vec_lo + 16'd1)); // R7
endmodule

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int KEY_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_flag = 1'b1;
    logic        brk_req = 1'b0;
    logic [7:0]  int_evt = '0;
    logic [4:0]  pin_ext = '0;
    logic [4:0]  edge_rise = 5'b11111;
    logic [KEY_W-1:0] key_in = '1;
    logic        adt_pin = 1'b1;
    logic        ad_eoc = 1'b0;
    logic        lvl15_pin_sel = 1'b1;
    logic        wr_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [14:0] wr_data = '0;
    logic        ack = 1'b0;
    logic        irq_pend;
    logic [4:0]  src_idx;
    logic [15:0] vec_hi;
    logic [15:0] vec_lo;
    logic        set_iflag;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int    idx;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vec_ctrl #(.KEY_W(KEY_W)) uut (
        .clk (clk), .rst_n (rst_n), .i_flag (i_flag), .brk_req (brk_req),
        .int_evt (int_evt), .pin_ext (pin_ext), .edge_rise (edge_rise),
        .key_in (key_in), .adt_pin (adt_pin), .ad_eoc (ad_eoc),
        .lvl15_pin_sel (lvl15_pin_sel), .wr_req (wr_req), .wr_en (wr_en),
        .wr_data (wr_data), .ack (ack), .irq_pend (irq_pend),
        .src_idx (src_idx), .vec_hi (vec_hi), .vec_lo (vec_lo),
        .set_iflag (set_iflag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_none(input string tag);
        chk(irq_pend == 1'b0, tag, int'(irq_pend), 0);
    endtask

    task automatic chk_idx(input int idx, input string tag);
        chk(irq_pend == 1'b1 && int'(src_idx) == idx, tag,
            irq_pend ? int'(src_idx) : -1, idx);
    endtask

    // driver: queue the expected winner and accept for one cycle
    task automatic take(input int idx, input string tag);
        sb_q.push_back('{idx, tag});
        ack = 1'b1;
        step(1);
        ack = 1'b0;
    endtask

    task automatic pulse_evt(input int b);
        int_evt[b] = 1'b1;
        step(1);
        int_evt = '0;
    endtask

    // monitor: compare every accepted item with the scoreboard head
    always @(negedge clk) begin
        #2;
        if (ack) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "scoreboard empty", int'(src_idx), -1);
            end else begin
                exp_t e;
                logic [15:0] eh;
                e  = sb_q.pop_front();
                eh = 16'hFFFD - 16'(2 * e.idx);
                chk(irq_pend && int'(src_idx) == e.idx, {e.tag, " index"},
                    int'(src_idx), e.idx);
                chk(vec_hi == eh && vec_lo == eh - 16'd1, {e.tag, " vector R7"},
                    int'(vec_hi), int'(eh));
                chk(set_iflag == 1'b1, {e.tag, " set_iflag R5"}, int'(set_iflag), 1);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset entry first, then gone
        chk_idx(0, "R1 reset entry pending");
        take(0, "R1 reset entry");
        chk_none("R1 reset entry cleared");

        // R2 masking by enable and i_flag
        i_flag = 1'b0;
        pulse_evt(2);
        chk_none("R2 disabled source held off");
        wr_en = 1'b1; wr_data = '1; step(1); wr_en = 1'b0;
        chk_idx(5, "R2 enabled source taken");
        i_flag = 1'b1; #1;
        chk_none("R2 i_flag masks");
        i_flag = 1'b0;

        // R4 software writes
        wr_req = 1'b1; wr_data = '1; step(1); wr_req = 1'b0;
        chk_idx(5, "R4 write of ones keeps request");
        wr_req = 1'b1; wr_data = ~(15'd1 << 4); step(1); wr_req = 1'b0;
        chk_none("R4 write of zero clears request");

        // R3 R5 R11 priority among simultaneous events
        int_evt[7] = 1'b1; int_evt[0] = 1'b1; step(1); int_evt = '0;
        chk_idx(3, "R3 R11 lower level wins");
        take(3, "R3 level 3");
        chk_idx(13, "R5 other request stays latched");
        take(13, "R5 level 13");
        chk_none("R5 all served");

        // R6 break ignores i_flag
        i_flag = 1'b1;
        brk_req = 1'b1; step(1); brk_req = 1'b0;
        chk_idx(16, "R6 break with i_flag set");
        take(16, "R6 break");
        i_flag = 1'b0;
        brk_req = 1'b1; int_evt[6] = 1'b1; step(1); brk_req = 1'b0; int_evt = '0;
        take(11, "R3 maskable beats break");
        take(16, "R3 break after maskable");
        chk_none("R6 break cleared");

        // R8 rising edge on pin bit 1 (level 2), sync latency
        pin_ext[1] = 1'b1;
        step(2);
        chk_none("R8 not yet after two clocks");
        step(1);
        chk_idx(2, "R8 rising edge third clock");
        take(2, "R8 level 2");
        pin_ext[1] = 1'b0;
        step(4);
        chk_none("R8 falling edge ignored when rising selected");

        // R10 edge-select change raises spurious request on level 12
        edge_rise[4] = 1'b0;
        step(1);
        chk_idx(12, "R10 select change sets request");
        edge_rise[4] = 1'b1;
        wr_req = 1'b1; wr_data = ~(15'd1 << 11); step(1); wr_req = 1'b0;
        chk_none("R10 spurious request cleared by write");

        // R9 key wake-up
        key_in[1] = 1'b0;
        step(3);
        chk_idx(14, "R9 key line low");
        take(14, "R9 level 14");
        key_in[1] = 1'b1;
        step(4);
        chk_none("R9 key release no request");

        // R10 shared level, conversion source
        lvl15_pin_sel = 1'b0;
        step(2);
        chk_none("R10 switch with inactive source quiet");
        ad_eoc = 1'b1; step(1); ad_eoc = 1'b0;
        chk_idx(15, "R10 conversion complete");
        take(15, "R10 level 15 conversion");
        lvl15_pin_sel = 1'b1;
        step(1);
        adt_pin = 1'b0;
        step(3);
        chk_idx(15, "R10 trigger pin falling");
        take(15, "R10 level 15 pin");
        adt_pin = 1'b1;
        step(3);
        chk_none("R10 trigger pin rising ignored");

        // R11 hardware set wins over same-cycle accept clear
        pulse_evt(2);
        sb_q.push_back('{5, "R11 accept with new event"});
        ack = 1'b1; int_evt[2] = 1'b1;
        step(1);
        ack = 1'b0; int_evt = '0;
        chk_idx(5, "R11 set wins over clear");
        take(5, "R11 level 5 again");
        chk_none("R11 finally clear");

        step(2);
        chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule